// File: doc/BRIEF.md
# Redundant Bus Clock Failure Monitor

This block supervises two redundant bus clocks, called A and B, together with the frame pulse they share. It samples them with a fast local clock. Each bus clock is judged on two independent criteria at the same time. The first is the timing of every rising edge: the gap since the previous rising edge, counted in local ticks, must fall inside a tolerance window around the nominal period. The second is the frame length: the number of rising edges between two consecutive frame pulses must equal a fixed count. A clock that stops altogether is caught as soon as the late limit of the window has passed, without waiting for another edge.

Detected faults set sticky per-clock flags. Each flag is cleared by writing one to its bit. The flags drive a maskable interrupt. One of the two clocks is the selected source. When automatic failover is enabled and the selected clock is flagged while the other one is clean, the block moves the selection to the other clock. It then pulses a resynchronization request for the downstream timing logic. If both clocks are flagged, the selection is kept and a double-failure flag is raised.

Top module: `busclk_guard`

## Requirements
- R1: After reset, flags_o is 3'b000, irq_o is 0, resync_o is 0 and sel_o equals DEFAULT_SEL (0 selects clock A, 1 selects clock B).
- R2: A rising edge whose distance from the previous rising edge on the same clock is between NOM_TICKS-TOL_TICKS and NOM_TICKS+TOL_TICKS local ticks, inclusive, raises no flag. Any shorter or longer distance sets that clock's flag: flags_o bit 0 for A, bit 1 for B.
- R3: A clock that has had at least one rising edge and then shows none for more than NOM_TICKS+TOL_TICKS ticks is flagged while it is still stopped.
- R4: At each frame pulse rising edge, a clock whose rising-edge count since the previous frame pulse differs from FRAME_CYC is flagged. A rising edge seen in the same sample as the frame edge counts toward the new frame.
- R5: The first frame pulse after reset, or after a switchover, only starts the count and does not check it.
- R6: Both clocks are checked continuously, whichever one is selected.
- R7: Flags stay set until clear_i has a one in the same bit position (bit 2 clears the double-failure flag). A new fault in the same cycle wins over the clear.
- R8: irq_o is high exactly when some flag is set and its bit in irq_en_i is also set.
- R9: With failover_en_i high, a flagged selected clock and a clean other clock, sel_o switches to the other clock and resync_o is high for exactly one cycle. There is no switch back while the new selection stays clean.
- R10: With failover_en_i low, sel_o never changes.
- R11: With failover_en_i high and both clock flags set, sel_o is kept and flags_o bit 2 (double failure) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_a_i | input | 1 | Redundant bus clock A, asynchronous |
| bus_clk_b_i | input | 1 | Redundant bus clock B, asynchronous |
| frame_i | input | 1 | Shared frame pulse, asynchronous |
| failover_en_i | input | 1 | Enables automatic switchover |
| irq_en_i | input | 3 | Interrupt enable per flag (A, B, double) |
| clear_i | input | 3 | Write-one-to-clear per flag |
| flags_o | output | 3 | Sticky flags: bit 0 A, bit 1 B, bit 2 double failure |
| irq_o | output | 1 | Masked OR of the flags |
| sel_o | output | 1 | Selected clock (0 = A, 1 = B) |
| resync_o | output | 1 | One-cycle resynchronization request on switchover |

## Verification
The bench drives clean clocks with random per-period jitter across the whole allowed window and random observation gaps. This shows that in-window timing and exact frame lengths never raise a flag, including the partial first frame after reset. Single extra edges separate the early-edge case from stopped clocks, which exercise the stall detection. Frames lengthened or shortened by one cycle hit the count check alone on both clocks at once. That simultaneous fault, together with failover on or off and faults placed on the selected or the backup clock, tells a real switchover apart from a held selection and a double failure.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int NUM_CLK = 2;
  localparam int FLAG_W  = 3;
  localparam int FL_A    = 0;
  localparam int FL_B    = 1;
  localparam int FL_DBL  = 2;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } clk_sel_e;
endpackage

// File: rtl/busclk_sync.sv
module busclk_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/busclk_edge_mon.sv
module busclk_edge_mon #(
  parameter int NOM_TICKS = 16,
  parameter int TOL_TICKS = 4,
  parameter int FRAME_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_s_i,
  input  logic frame_rise_i,
  input  logic rearm_i,
  output logic fault_o
);
  localparam int LATE  = NOM_TICKS + TOL_TICKS;
  localparam int EARLY = NOM_TICKS - TOL_TICKS;
  localparam int TW    = $clog2(LATE + 2);
  localparam int FW    = $clog2(FRAME_CYC + 2);
  localparam logic [TW-1:0] LATE_T  = TW'(LATE);
  localparam logic [TW-1:0] EARLY_T = TW'(EARLY);
  localparam logic [TW-1:0] SAT_T   = TW'(LATE + 1);
  localparam logic [FW-1:0] FRM_T   = FW'(FRAME_CYC);
  localparam logic [FW-1:0] FSAT_T  = FW'(FRAME_CYC + 1);

  logic          clk_d, rise, armed;
  logic [TW-1:0] tick_cnt;
  logic          frm_valid;
  logic [FW-1:0] frm_cnt;
  logic          tmr_fault, cnt_fault, fault_q;

  assign rise = clk_s_i & ~clk_d;

  // tick_cnt equals the interval in ticks when the next rise is seen
  always_comb begin
    tmr_fault = 1'b0;
    if (armed) begin
      if (rise) tmr_fault = (tick_cnt < EARLY_T) || (tick_cnt > LATE_T);
      else      tmr_fault = (tick_cnt == LATE_T);
    end
  end

  assign cnt_fault = frame_rise_i && frm_valid && (frm_cnt != FRM_T);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d    <= 1'b0;
      armed    <= 1'b0;
      tick_cnt <= '0;
    end else begin
      clk_d <= clk_s_i;
      if (rise) begin
        armed    <= 1'b1;
        tick_cnt <= TW'(1);
      end else if (armed && tick_cnt != SAT_T) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_valid <= 1'b0;
      frm_cnt   <= '0;
    end else if (rearm_i) begin
      frm_valid <= 1'b0;
      frm_cnt   <= '0;
    end else if (frame_rise_i) begin
      frm_valid <= 1'b1;
      frm_cnt   <= rise ? FW'(1) : '0;
    end else if (rise && frm_cnt != FSAT_T) begin
      frm_cnt <= frm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= tmr_fault | cnt_fault;
  end

  assign fault_o = fault_q;

  p_window_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rise && !frame_rise_i && tick_cnt >= EARLY_T && tick_cnt <= LATE_T) |=> !fault_o);

  p_fault_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(rise || frame_rise_i || tick_cnt == LATE_T));

  p_first_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_rise_i && !frm_valid && !tmr_fault) |=> !fault_o);
endmodule

// File: rtl/busclk_select.sv
module busclk_select
  import busclk_pkg::*;
#(
  parameter bit DEFAULT_SEL = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               failover_en_i,
  input  logic [NUM_CLK-1:0] fail_i,
  output logic               sel_o,
  output logic               resync_o,
  output logic               dbl_o
);
  clk_sel_e sel_q;
  logic     resync_q;
  logic     fail_cur, fail_oth;

  assign fail_cur = fail_i[sel_q];
  assign fail_oth = fail_i[~sel_q];
  assign dbl_o    = failover_en_i && fail_cur && fail_oth;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= clk_sel_e'(DEFAULT_SEL);
      resync_q <= 1'b0;
    end else begin
      resync_q <= 1'b0;
      if (failover_en_i && fail_cur && !fail_oth) begin
        sel_q    <= (sel_q == SEL_A) ? SEL_B : SEL_A;
        resync_q <= 1'b1;
      end
    end
  end

  assign sel_o    = sel_q;
  assign resync_o = resync_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !failover_en_i |=> sel_q == $past(sel_q));

  p_switch_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> ($past(fail_i) == ($past(sel_q) == SEL_B ? 2'b10 : 2'b01)));

  p_resync_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_q |=> !resync_q);
endmodule

// File: rtl/busclk_guard.sv
module busclk_guard
  import busclk_pkg::*;
#(
  parameter int NOM_TICKS   = 16,
  parameter int TOL_TICKS   = 4,
  parameter int FRAME_CYC   = 1024,
  parameter bit DEFAULT_SEL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clk_a_i,
  input  logic              bus_clk_b_i,
  input  logic              frame_i,
  input  logic              failover_en_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  input  logic [FLAG_W-1:0] clear_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              sel_o,
  output logic              resync_o
);
  logic [NUM_CLK:0]   sync_q;
  logic               frame_d, frame_rise;
  logic [NUM_CLK-1:0] mon_fault;
  logic               dbl_set;
  logic [FLAG_W-1:0]  flags_q, flag_set;

  busclk_sync #(.W(NUM_CLK + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({frame_i, bus_clk_b_i, bus_clk_a_i}),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_d <= 1'b0;
    else         frame_d <= sync_q[NUM_CLK];
  end
  assign frame_rise = sync_q[NUM_CLK] & ~frame_d;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
    busclk_edge_mon #(
      .NOM_TICKS(NOM_TICKS),
      .TOL_TICKS(TOL_TICKS),
      .FRAME_CYC(FRAME_CYC)
    ) u_mon (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clk_s_i     (sync_q[g]),
      .frame_rise_i(frame_rise),
      .rearm_i     (resync_o),
      .fault_o     (mon_fault[g])
    );
  end

  busclk_select #(.DEFAULT_SEL(DEFAULT_SEL)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .failover_en_i(failover_en_i),
    .fail_i       (flags_q[NUM_CLK-1:0]),
    .sel_o        (sel_o),
    .resync_o     (resync_o),
    .dbl_o        (dbl_set)
  );

  assign flag_set = {dbl_set, mon_fault};

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flag_set | (flags_q & ~clear_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & irq_en_i);

  for (genvar f = 0; f < FLAG_W; f++) begin : g_chk
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[f] && !clear_i[f]) |=> flags_q[f]);
  end

  p_dbl_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[FL_DBL]) |-> $past(flags_q[FL_B:FL_A] == 2'b11));

  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == '0) |-> !irq_o);
endmodule

// File: tb/test_busclk_guard.sv
module test_busclk_guard;
  localparam int NOM = 8;
  localparam int TOL = 2;
  localparam int FRM = 32;
  localparam int FRAME_WAIT = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_a = 1'b0, bus_b = 1'b0, frame = 1'b0;
  logic       failover_en = 1'b0;
  logic [2:0] irq_en = 3'b111;
  logic [2:0] clear = 3'b000;
  logic [2:0] flags;
  logic       irq, sel, resync;

  int n_chk = 0, n_fail = 0, n_resync = 0;
  bit done = 1'b0;

  // stimulus controls (written by initial only)
  bit kill_a = 0, kill_b = 0, xtra_a = 0, xtra_b = 0;
  int frm_len = FRM;
  // generator state (written by always only)
  int ph = 0, cur_per = NOM, frm_idx = 0;

  always #5 clk = ~clk;

  busclk_guard #(.NOM_TICKS(NOM), .TOL_TICKS(TOL), .FRAME_CYC(FRM), .DEFAULT_SEL(1'b0)) i_busclk_guard (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_a_i(bus_a), .bus_clk_b_i(bus_b), .frame_i(frame),
    .failover_en_i(failover_en), .irq_en_i(irq_en), .clear_i(clear),
    .flags_o(flags), .irq_o(irq), .sel_o(sel), .resync_o(resync)
  );

  always @(negedge clk) begin
    if (ph + 1 >= cur_per) begin
      ph = 0;
      cur_per = NOM - TOL + int'($urandom_range(2 * TOL, 0));
      frm_idx = (frm_idx + 1 >= frm_len) ? 0 : frm_idx + 1;
    end else begin
      ph = ph + 1;
    end
    bus_a = !kill_a && (ph < 3 || (xtra_a && ph == 4));
    bus_b = !kill_b && (ph < 3 || (xtra_b && ph == 4));
    frame = (frm_idx == 0) && (ph == 4 || ph == 5);
    if (resync && rst_n) n_resync++;
  end

  function automatic int exp_irq(input logic [2:0] f, input logic [2:0] en);
    return int'(|(f & en));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear(input logic [2:0] v);
    @(negedge clk) clear = v;
    @(negedge clk) clear = 3'b000;
  endtask

  task automatic pulse_extra(input bit on_b);
    while (ph != 1) @(posedge clk);
    if (on_b) xtra_b = 1; else xtra_a = 1;
    while (ph != 5) @(posedge clk);
    xtra_a = 0;
    xtra_b = 0;
  endtask

  task automatic odd_frame(input int len);
    while (frm_idx != 1) @(posedge clk);
    frm_len = len;
    while (frm_idx != 0) @(posedge clk);
    frm_len = FRM;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4711);
    wait_cyc(6);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 sel", sel, 0);
    check("R1 resync", resync, 0);

    // R2/R4/R5: jittered clean clocks, partial first frame, random gaps
    for (int i = 0; i < 4; i++) begin
      wait_cyc(int'($urandom_range(400, 150)));
      check("R2 R4 R5 clean jitter", flags, 0);
    end
    wait_cyc(FRAME_WAIT);
    check("R5 clean after frames", flags, 0);

    // R2/R6: early edge on unselected B
    pulse_extra(1'b1);
    wait_cyc(20);
    check("R2 R6 early edge B", flags, 3'b010);
    check("R8 irq on", irq, exp_irq(flags, irq_en));
    check("R10 sel held", sel, 0);
    wait_cyc(2 * FRAME_WAIT);
    check("R7 sticky", flags, 3'b010);
    do_clear(3'b010);
    wait_cyc(2);
    check("R7 cleared", flags, 0);

    // R3: stopped clock A
    kill_a = 1;
    wait_cyc(25);
    check("R3 stall A", flags, 3'b001);
    check("R10 no failover", sel, 0);
    irq_en = 3'b010;
    wait_cyc(1);
    check("R8 masked", irq, exp_irq(flags, irq_en));
    irq_en = 3'b001;
    wait_cyc(1);
    check("R8 enabled", irq, 1);
    irq_en = 3'b111;

    // R9: failover to clean B
    failover_en = 1;
    wait_cyc(10);
    check("R9 switch to B", sel, 1);
    check("R9 one resync", n_resync, 1);
    kill_a = 0;
    wait_cyc(3 * FRAME_WAIT);
    do_clear(3'b001);
    wait_cyc(3);
    check("R9 clean after resume", flags, 0);
    check("R9 no switch back", sel, 1);

    // R4/R11: long frame hits both clocks
    odd_frame(FRM + 1);
    wait_cyc(20);
    check("R4 R11 long frame", flags, 3'b111);
    check("R11 sel kept", sel, 1);
    check("R11 no resync", n_resync, 1);
    do_clear(3'b011);
    do_clear(3'b100);
    wait_cyc(2);
    check("R7 all cleared", flags, 0);

    // R9: selected B stops, switch back to A
    kill_b = 1;
    wait_cyc(25);
    check("R9 switch to A", sel, 0);
    check("R9 second resync", n_resync, 2);
    check("R11 no dbl", flags, 3'b010);
    kill_b = 0;
    wait_cyc(3 * FRAME_WAIT);
    do_clear(3'b010);
    wait_cyc(3);
    check("R6 clean again", flags, 0);

    // R4: short frame
    odd_frame(FRM - 1);
    wait_cyc(20);
    check("R4 short frame", flags, 3'b111);
    check("R11 sel kept A", sel, 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule